// File: doc/BRIEF.md
# Asynchronous Serial Port with Modem Flow Control

This block is a full-duplex asynchronous serial port. It sends one byte at a time on a transmit line and receives bytes on a receive line. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit and one high stop bit. Bit timing comes from a clock-enable pulse, `baud_tick`, which a separate rate generator produces at `OVERSAMPLE` pulses per bit time. The transmitter changes its line only on a bit boundary. The receiver samples in the middle of each bit.

Flow control uses two active-low modem lines. A new transmit frame starts only while `cts_n` is low. Every change on `cts_n` is recorded as an interrupt event. The `rts_n` output is chosen by a mode field. It can follow a software level, or it can be driven by the receiver according to the fill state of its one-byte holding register. It can also be driven by the transmitter according to whether a byte is queued or being sent. In local loop-back mode the transmit stream feeds the receiver internally. The transmit pin stays at mark and the receive pin is ignored.

Software reaches the block through a small register port with four addresses: data, interrupt status, interrupt mask and control. The active-low interrupt line is low whenever a status bit is set and that bit is unmasked.

Top module: `uart_flow_core`

## Requirements
- R1: `txd` is 1 whenever the transmitter is disabled (control bit 0 = 0), has no frame in progress, or loop-back (control bit 2) is set.
- R2: A transmitted frame is made of the following bits, each lasting `OVERSAMPLE` ticks, with the line changing only at bit boundaries:
  - a start bit at 0;
  - data bits 0 to 7, least significant bit first;
  - when control bit 6 is set, a parity bit, even when control bit 7 = 0 and odd when it is 1;
  - a stop bit at 1.
- R3: The receiver detects a start on a 1-to-0 transition and confirms it half a bit later. A low lasting less than half a bit is discarded. The receiver samples each bit at mid-bit, least significant bit first. A completed frame stores its byte in the holding register and sets status bit 0.
- R4: Every change of the synchronised `cts_n` sets status bit 2.
- R5: A frame starts only while `cts_n` is low. The transmit holding register holds one byte. A write to address 0 while that byte has not yet been taken by the transmitter is ignored. Status bit 1 is set when a frame's stop bit ends.
- R6: Control bits 4:3 select how `rts_n` is driven:
  - 0: `rts_n` is the inverse of control bit 5.
  - 1 (receiver): `rts_n` is 1 while the receive holding register is full and returns to 0 after the register is read.
  - 2 (transmitter): `rts_n` is 0 while a byte is queued or a frame is in progress, and returns to 1 after the stop bit.
- R7: `irq_n` is the NOR of the bitwise AND of the status register (address 1) and the mask register (address 2).
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: A stop bit sampled low sets status bit 3. When parity is enabled, a parity bit that does not match sets status bit 4.
- R10: A frame that completes while the receive holding register is full sets status bit 5 and is dropped. The held byte is unchanged.
- R11: In loop-back mode the receiver takes the transmitter's internal stream, and the `rxd` pin has no effect.
- R12: Register map:
  - address 0: data, where a write queues a byte and a read with `reg_rd` takes the received byte;
  - address 1: status, 6 bits;
  - address 2: mask;
  - address 3: control.

  After reset all registers are 0, both holding registers are empty, `irq_n` and `rts_n` are 1, and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Clock enable, OVERSAMPLE pulses per bit |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Read strobe; at address 0 it empties the receive holding register |
| reg_rdata | output | 8 | Read data for the addressed register |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest situation to reach from the ports is a frame that completes while the receive holding register is still full. The overrun bit must be set, and the byte already held must survive. The bench reaches this case by sending two complete frames back to back on `rxd` without reading in between, and only then reads the status and the data. Two other cases also need the bench to shape the line bit by bit: a stop bit sampled low, and a start pulse shorter than half a bit. Loop-back is checked while `rxd` is held low for the whole frame, so that any leak from the pin would corrupt the received byte.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int ADDR_W = 2;
  localparam int REG_W  = 8;
  localparam int ISR_W  = 6;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_ISR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_IMR  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;

  localparam int IS_RXRDY  = 0;
  localparam int IS_TXDONE = 1;
  localparam int IS_CTS    = 2;
  localparam int IS_FERR   = 3;
  localparam int IS_PERR   = 4;
  localparam int IS_OVR    = 5;

  typedef enum logic [1:0] {
    RTS_MANUAL = 2'd0,
    RTS_BY_RX  = 2'd1,
    RTS_BY_TX  = 2'd2,
    RTS_RSVD   = 2'd3
  } rts_mode_e;

  typedef struct packed {
    logic      par_odd;   // bit 7
    logic      par_en;    // bit 6
    logic      rts_level; // bit 5
    rts_mode_e rts_mode;  // bits 4:3
    logic      loop_en;   // bit 2
    logic      rx_en;     // bit 1
    logic      tx_en;     // bit 0
  } ctrl_t;

  function automatic logic parity_of(logic [7:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [3:0] last_bit_idx(logic par_en);
    return par_en ? 4'd10 : 4'd9;
  endfunction

  function automatic logic frame_bit(logic [7:0] d, logic [3:0] idx,
                                     logic par_en, logic odd);
    if (idx == 4'd0) return 1'b0;
    if (idx <= 4'd8) return d[3'(idx - 4'd1)];
    if (idx == 4'd9 && par_en) return parity_of(d, odd);
    return 1'b1;
  endfunction
endpackage

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       cts_ok,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       hold_full,
  input  logic [7:0] hold_data,
  output logic       load,
  output logic       busy,
  output logic       done,
  output logic       line
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

  logic [CNT_W-1:0] cnt;
  logic [3:0]       idx;
  logic [7:0]       sh;
  logic             p_en, p_odd;

  assign load = !busy && enable && hold_full && cts_ok && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; line <= 1'b1;
      cnt <= '0; idx <= '0; sh <= '0; p_en <= 1'b0; p_odd <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1; sh <= hold_data; p_en <= par_en; p_odd <= par_odd;
        idx <= '0; cnt <= '0; line <= 1'b0;
      end else if (busy && tick) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          if (idx == last_bit_idx(p_en)) begin
            busy <= 1'b0; done <= 1'b1; line <= 1'b1;
          end else begin
            idx  <= idx + 4'd1;
            line <= frame_bit(sh, idx + 4'd1, p_en, p_odd);
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line);
  p_done_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && line));
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       line,
  output logic       done,
  output logic [7:0] data,
  output logic       frame_err,
  output logic       par_err
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVERSAMPLE / 2 - 1);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_state_e;

  rx_state_e        st;
  logic             s1, s2, prev;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       idx;
  logic [7:0]       sh;

  assign data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1;
    end else begin
      s1 <= line; s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_IDLE; prev <= 1'b1; cnt <= '0; idx <= '0; sh <= '0;
      done <= 1'b0; frame_err <= 1'b0; par_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        st <= R_IDLE;
      end else if (tick) begin
        prev <= s2;
        case (st)
          R_IDLE: if (prev && !s2) begin st <= R_START; cnt <= '0; end
          R_START: begin
            if (cnt == CNT_HALF) begin
              cnt <= '0; idx <= '0; par_err <= 1'b0;
              st <= s2 ? R_IDLE : R_DATA;
            end else cnt <= cnt + 1'b1;
          end
          R_DATA: begin
            if (cnt == CNT_LAST) begin
              cnt <= '0; sh <= {s2, sh[7:1]}; idx <= idx + 3'd1;
              if (idx == 3'd7) st <= par_en ? R_PAR : R_STOP;
            end else cnt <= cnt + 1'b1;
          end
          R_PAR: begin
            if (cnt == CNT_LAST) begin
              cnt <= '0; par_err <= (s2 != parity_of(sh, par_odd)); st <= R_STOP;
            end else cnt <= cnt + 1'b1;
          end
          R_STOP: begin
            if (cnt == CNT_LAST) begin
              cnt <= '0; st <= R_IDLE; done <= 1'b1; frame_err <= !s2;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st == R_IDLE);
endmodule

// File: rtl/uart_flow_core.sv
module uart_flow_core
  import uart_fc_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       cts_n,
  output logic       rts_n,
  output logic       irq_n
);
  ctrl_t            ctrl_q;
  logic [ISR_W-1:0] imr_q, isr_q, isr_set, isr_clr;
  logic [7:0]       tx_hold, rx_hold;
  logic             tx_full, rx_full;
  logic             cts_s1, cts_s2, cts_s3;

  logic       wr_data, rd_data_take, cts_edge, rts_assert;
  logic       tx_load, tx_busy, tx_done, tx_line, rx_line;
  logic       rx_done, rx_ferr, rx_perr, rx_store, rx_overrun;
  logic [7:0] rx_byte;

  assign wr_data      = reg_wr && reg_addr == A_DATA;
  assign rd_data_take = reg_rd && reg_addr == A_DATA;
  assign cts_edge     = cts_s2 ^ cts_s3;
  assign rx_store     = rx_done && !rx_full;
  assign rx_overrun   = rx_done && rx_full;
  assign rx_line      = ctrl_q.loop_en ? tx_line : rxd;
  assign txd          = ctrl_q.loop_en ? 1'b1 : tx_line;

  uart_fc_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk, .rst_n, .tick(baud_tick), .enable(ctrl_q.tx_en), .cts_ok(!cts_s2),
    .par_en(ctrl_q.par_en), .par_odd(ctrl_q.par_odd), .hold_full(tx_full),
    .hold_data(tx_hold), .load(tx_load), .busy(tx_busy), .done(tx_done),
    .line(tx_line));

  uart_fc_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk, .rst_n, .tick(baud_tick), .enable(ctrl_q.rx_en),
    .par_en(ctrl_q.par_en), .par_odd(ctrl_q.par_odd), .line(rx_line),
    .done(rx_done), .data(rx_byte), .frame_err(rx_ferr), .par_err(rx_perr));

  always_comb begin
    isr_set            = '0;
    isr_set[IS_RXRDY]  = rx_store;
    isr_set[IS_TXDONE] = tx_done;
    isr_set[IS_CTS]    = cts_edge;
    isr_set[IS_FERR]   = rx_done && rx_ferr;
    isr_set[IS_PERR]   = rx_done && rx_perr;
    isr_set[IS_OVR]    = rx_overrun;
    isr_clr = (reg_wr && reg_addr == A_ISR) ? reg_wdata[ISR_W-1:0] : '0;
  end

  always_comb begin
    case (ctrl_q.rts_mode)
      RTS_BY_RX: rts_assert = !rx_full;
      RTS_BY_TX: rts_assert = tx_full || tx_busy;
      default:   rts_assert = ctrl_q.rts_level;
    endcase
  end
  assign rts_n = !rts_assert;
  assign irq_n = ~|(isr_q & imr_q);

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rx_hold;
      A_ISR:   reg_rdata = {{(REG_W-ISR_W){1'b0}}, isr_q};
      A_IMR:   reg_rdata = {{(REG_W-ISR_W){1'b0}}, imr_q};
      default: reg_rdata = ctrl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; imr_q <= '0; isr_q <= '0;
      tx_hold <= '0; tx_full <= 1'b0; rx_hold <= '0; rx_full <= 1'b0;
      cts_s1 <= 1'b1; cts_s2 <= 1'b1; cts_s3 <= 1'b1;
    end else begin
      cts_s1 <= cts_n; cts_s2 <= cts_s1; cts_s3 <= cts_s2;
      isr_q  <= (isr_q & ~isr_clr) | isr_set;
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata);
      if (reg_wr && reg_addr == A_IMR)  imr_q  <= reg_wdata[ISR_W-1:0];
      if (tx_load) tx_full <= 1'b0;
      else if (wr_data && !tx_full) begin
        tx_full <= 1'b1; tx_hold <= reg_wdata;
      end
      if (rx_store) begin
        rx_full <= 1'b1; rx_hold <= rx_byte;
      end else if (rd_data_take) rx_full <= 1'b0;
    end
  end

  p_cts_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cts_edge |=> isr_q[IS_CTS]);
  p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full && !tx_load) |=> $stable(tx_hold));
  p_load_needs_cts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (tx_full && !cts_s2));
  p_rts_rx_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.rts_mode == RTS_BY_RX && rx_store && !(reg_wr && reg_addr == A_CTRL)) |=> rts_n);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr[IS_RXRDY] && !isr_set[IS_RXRDY]) |=> !isr_q[IS_RXRDY]);
  p_overrun_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> ($stable(rx_hold) && isr_q[IS_OVR]));
  p_loop_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.loop_en && tx_busy) |-> txd);
endmodule

// File: tb/uart_flow_core_tb.sv
module uart_flow_core_tb;
  localparam int OS = 16;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic rxd = 1'b1, txd, cts_n = 1'b1, rts_n, irq_n;

  int n_chk = 0, n_err = 0, mark_bad = 0;
  bit mark_watch = 1'b0;

  always #5 clk = ~clk;

  uart_flow_core #(.OVERSAMPLE(OS)) u_dut (
    .clk, .rst_n, .baud_tick, .reg_addr, .reg_wr, .reg_wdata, .reg_rd,
    .reg_rdata, .rxd, .txd, .cts_n, .rts_n, .irq_n);

  // Per-clock model: the line must sit at mark inside every watched window.
  always @(negedge clk) if (mark_watch && txd !== 1'b1) mark_bad++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit take, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = take; #1; d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit with_par, input bit pv,
                      input bit stop_v);
    @(negedge clk);
    rxd = 1'b0; repeat (OS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (OS) @(negedge clk); end
    if (with_par) begin rxd = pv; repeat (OS) @(negedge clk); end
    rxd = stop_v; repeat (OS) @(negedge clk);
    rxd = 1'b1; repeat (OS + 8) @(negedge clk);
  endtask

  task automatic capture(input bit with_par, output logic [7:0] d,
                         output bit p, output bit stop, output bit found);
    found = 1'b0; d = '0; p = 1'b0; stop = 1'b0;
    for (int w = 0; w < 2000 && !found; w++) begin
      @(negedge clk); if (txd === 1'b0) found = 1'b1;
    end
    if (found) begin
      repeat (OS / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin repeat (OS) @(negedge clk); d[i] = txd; end
      if (with_par) begin repeat (OS) @(negedge clk); p = txd; end
      repeat (OS) @(negedge clk); stop = txd;
    end
  endtask

  task automatic watch_mark(input int cycles, input string req);
    mark_bad = 0; mark_watch = 1'b1;
    repeat (cycles) @(negedge clk);
    mark_watch = 1'b0;
    check(mark_bad == 0, req, "txd left mark", mark_bad, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] v, d;
    bit p, stop, found;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_n == 1'b1, "R12", "irq_n reset", irq_n, 1);
    check(rts_n == 1'b1, "R12", "rts_n reset", rts_n, 1);
    check(txd == 1'b1, "R1", "txd reset", txd, 1);
    rd(2'd1, 0, v); check(v == 8'h00, "R12", "status reset", v, 0);
    rd(2'd3, 0, v); check(v == 8'h00, "R12", "control reset", v, 0);

    // R4: clear-to-send change
    cts_n = 1'b0; repeat (6) @(negedge clk);
    rd(2'd1, 0, v); check(v == 8'h04, "R4", "cts event", v, 8'h04);
    wr(2'd1, 8'h04);
    rd(2'd1, 0, v); check(v == 8'h00, "R8", "w1c clears", v, 0);

    // R1: disabled transmitter stays at mark, then R2 frame
    wr(2'd0, 8'hA5);
    watch_mark(300, "R1");
    wr(2'd3, 8'h01);
    capture(0, d, p, stop, found);
    check(found && d == 8'hA5, "R2", "tx byte", d, 8'hA5);
    check(stop == 1'b1, "R2", "tx stop", stop, 1);
    repeat (20) @(negedge clk);
    rd(2'd1, 0, v); check(v == 8'h02, "R5", "tx done flag", v, 8'h02);
    wr(2'd1, 8'h3F);

    // R5: clear-to-send gating and one-byte holding
    cts_n = 1'b1; repeat (6) @(negedge clk); wr(2'd1, 8'h3F);
    wr(2'd0, 8'h3C);
    wr(2'd0, 8'hFF);
    watch_mark(300, "R5");
    cts_n = 1'b0;
    capture(0, d, p, stop, found);
    check(found && d == 8'h3C, "R5", "gated byte", d, 8'h3C);
    repeat (20) @(negedge clk);
    watch_mark(300, "R5");

    // R2: parity, odd then even
    wr(2'd3, 8'hC1); wr(2'd0, 8'h3C);
    capture(1, d, p, stop, found);
    check(d == 8'h3C && p == 1'b1, "R2", "odd parity", {p, d}, 9'h13C);
    check(stop == 1'b1, "R2", "stop after parity", stop, 1);
    repeat (20) @(negedge clk);
    wr(2'd3, 8'h41); wr(2'd0, 8'h03);
    capture(1, d, p, stop, found);
    check(d == 8'h03 && p == 1'b0, "R2", "even parity", {p, d}, 9'h003);
    repeat (20) @(negedge clk);

    // R6: transmitter-driven request-to-send
    wr(2'd3, 8'h11);
    check(rts_n == 1'b1, "R6", "tx mode idle", rts_n, 1);
    wr(2'd0, 8'h55);
    check(rts_n == 1'b0, "R6", "tx mode queued", rts_n, 0);
    capture(0, d, p, stop, found);
    check(rts_n == 1'b0, "R6", "tx mode in frame", rts_n, 0);
    repeat (20) @(negedge clk);
    check(rts_n == 1'b1, "R6", "tx mode after stop", rts_n, 1);
    wr(2'd3, 8'h20); check(rts_n == 1'b0, "R6", "manual on", rts_n, 0);
    wr(2'd3, 8'h00); check(rts_n == 1'b1, "R6", "manual off", rts_n, 1);

    // R3: reception and glitch rejection
    wr(2'd3, 8'h02); wr(2'd1, 8'h3F);
    send(8'h5A, 0, 0, 1);
    rd(2'd1, 0, v); check(v == 8'h01, "R3", "rx ready", v, 8'h01);
    rd(2'd0, 1, v); check(v == 8'h5A, "R3", "rx byte", v, 8'h5A);
    wr(2'd1, 8'h3F);
    @(negedge clk); rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (300) @(negedge clk);
    rd(2'd1, 0, v); check(v == 8'h00, "R3", "short low ignored", v, 0);

    // R6: receiver-driven request-to-send
    wr(2'd3, 8'h0A);
    check(rts_n == 1'b0, "R6", "rx mode empty", rts_n, 0);
    send(8'h81, 0, 0, 1);
    check(rts_n == 1'b1, "R6", "rx mode full", rts_n, 1);
    rd(2'd0, 1, v); check(v == 8'h81, "R3", "rx byte 81", v, 8'h81);
    check(rts_n == 1'b0, "R6", "rx mode after read", rts_n, 0);

    // R10: overrun
    wr(2'd3, 8'h02); wr(2'd1, 8'h3F);
    send(8'h11, 0, 0, 1);
    send(8'h22, 0, 0, 1);
    rd(2'd1, 0, v); check(v == 8'h21, "R10", "overrun flag", v, 8'h21);
    rd(2'd0, 1, v); check(v == 8'h11, "R10", "first byte kept", v, 8'h11);

    // R9: framing and parity errors
    wr(2'd1, 8'h3F);
    send(8'h33, 0, 0, 0);
    rd(2'd1, 0, v); check(v == 8'h09, "R9", "framing error", v, 8'h09);
    rd(2'd0, 1, v);
    wr(2'd3, 8'h42); wr(2'd1, 8'h3F);
    send(8'h0F, 1, 0, 1);
    rd(2'd1, 0, v); check(v == 8'h01, "R9", "good parity", v, 8'h01);
    rd(2'd0, 1, v); wr(2'd1, 8'h3F);
    send(8'h0F, 1, 1, 1);
    rd(2'd1, 0, v); check(v == 8'h11, "R9", "parity error", v, 8'h11);
    rd(2'd0, 1, v);

    // R7: masked interrupt
    wr(2'd3, 8'h02); wr(2'd1, 8'h3F); wr(2'd2, 8'h08);
    send(8'h44, 0, 0, 1);
    check(irq_n == 1'b1, "R7", "masked event", irq_n, 1);
    wr(2'd2, 8'h01);
    check(irq_n == 1'b0, "R7", "unmasked event", irq_n, 0);
    wr(2'd1, 8'h01);
    check(irq_n == 1'b1, "R8", "irq after w1c", irq_n, 1);
    rd(2'd0, 1, v); wr(2'd2, 8'h00);

    // R11: loop-back with the pin held low
    wr(2'd3, 8'h07); wr(2'd1, 8'h3F);
    rxd = 1'b0; mark_bad = 0; mark_watch = 1'b1;
    wr(2'd0, 8'hC3);
    for (int w = 0; w < 1000; w++) begin
      rd(2'd1, 0, v); if (v[1]) break;
    end
    mark_watch = 1'b0;
    check(mark_bad == 0, "R1", "mark in loop-back", mark_bad, 0);
    rd(2'd1, 0, v); check(v == 8'h03, "R11", "loop status", v, 8'h03);
    rd(2'd0, 1, v); check(v == 8'hC3, "R11", "loop byte", v, 8'hC3);
    rxd = 1'b1;

    finish_run();
  end
endmodule